// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer

This block is the in-order retirement queue of an out-of-order core. Decoded instructions claim entries at issue time, up to two per cycle, in program order. Each claimed entry receives a tag, which the function units later return with their result. Results arrive on two writeback lanes in any order. A result is parked in its entry and does not reach the architectural register file until that instruction retires.

Retirement happens at the oldest end of the queue only, and at most two instructions leave per cycle. A retiring register-writing instruction drives one of two register-file write lanes. A retiring store writes no register. Instead, it raises a store-release strobe that carries the store-buffer slot the store was given at issue. A flush input empties the queue at once and returns both pointers to zero, so that decode can restart after a redirect.

The queue is circular. Its head and tail pointers each carry one bit more than the index needs, which tells a full queue from an empty one when the two indices match. Depth, register index, data and store-slot widths are constants of the shared package.

Top module: `rob_dual_commit`

## Requirements
- R1: After reset no commit lane is active, and a request for two entries is accepted, with tags 0 and 1.
- R2: An accepted allocation gives lane 0 the tail index. Lane 1 gets the next index modulo the depth when lane 0 also requests, and the tail index otherwise. The tail advances by the number of entries granted.
- R3: Instructions retire strictly in allocation order whatever the writeback order. Each retiring lane shows the destination (or store slot) recorded at allocation and the value written back for that entry.
- R4: Two results can be written back in the same cycle. When the two oldest entries are both complete, both retire in the same cycle, with the older one on lane 0.
- R5: Lane 1 retires only in a cycle where lane 0 also retires. A complete second entry behind an incomplete oldest entry does not retire.
- R6: A retiring store raises its store-release strobe with its store-buffer slot and does not raise the register write enable on that lane.
- R7: When fewer entries are free than the number requested, alloc_ready is low and no entry is granted. The tail is unchanged, so the next accepted request receives the same tag.
- R8: Pointers wrap modulo the depth. With all eight entries occupied after a wrap, a request for one entry is refused. Once the queue drains, the next tag follows on from the wrapped index.
- R9: A flush invalidates every entry and sets both pointers to zero. Nothing retires while flush is high. A writeback that arrives afterwards for a flushed tag causes no retirement, and the next allocation gets tag 0.
- R10: A writeback whose tag names an unoccupied entry is ignored. That entry, once allocated later, does not retire until it receives its own writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries and zero both pointers |
| alloc_valid | input | 2 | Allocation request per lane (lane 0 is older) |
| alloc_dst | input | 2x5 | Destination register per allocation lane |
| alloc_store | input | 2 | Lane carries a store |
| alloc_sbidx | input | 2x3 | Store-buffer slot per allocation lane |
| alloc_ready | output | 1 | Enough free entries for every requesting lane |
| alloc_tag | output | 2x3 | Entry index granted to each allocation lane |
| wb_valid | input | 2 | Writeback strobe per result lane |
| wb_tag | input | 2x3 | Entry targeted by each writeback |
| wb_value | input | 2x32 | Result value per writeback lane |
| rf_we | output | 2 | Register-file write enable per retire lane |
| rf_addr | output | 2x5 | Register-file write address per retire lane |
| rf_data | output | 2x32 | Register-file write data per retire lane |
| st_commit | output | 2 | Store-release strobe per retire lane |
| st_idx | output | 2x3 | Store-buffer slot released per retire lane |

## Verification
alloc_ready and alloc_tag follow the request inputs in the same cycle. The bench therefore reads them shortly after driving a request and before the edge that grants it. A writeback captured at edge N makes its entry eligible, so the retire lanes show it during the cycle after edge N, and the entry leaves at edge N+1. Every retire observation is therefore taken at the falling edge that follows the writeback edge, when the ports are settled. A scoreboard queue filled at allocation time is popped at each falling edge for every active retire lane. This catches any reordering, any duplicate, or a retirement that should not have happened.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH = 8;
    localparam int IDX_W     = $clog2(ROB_DEPTH);
    localparam int PTR_W     = IDX_W + 1;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 32;
    localparam int SB_W      = 3;
    localparam int LANES     = 2;

    typedef logic [IDX_W-1:0] rob_idx_t;
    typedef logic [PTR_W-1:0] rob_ptr_t;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              is_store;
        logic [REG_W-1:0]  dst;
        logic [SB_W-1:0]   sbidx;
        logic [DATA_W-1:0] value;
    } rob_entry_t;

    function automatic logic [1:0] lane_count(input logic [1:0] v);
        return {1'b0, v[0]} + {1'b0, v[1]};
    endfunction

    function automatic rob_ptr_t ptr_add(input rob_ptr_t p, input logic [1:0] n);
        return p + rob_ptr_t'(n);
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import rob_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [LANES-1:0]      alloc_valid,
    input  logic [1:0]            retire_cnt,
    output logic                  alloc_ready,
    output logic [LANES-1:0]      alloc_fire,
    output rob_idx_t              alloc_idx [LANES],
    output rob_ptr_t              head_ptr,
    output rob_ptr_t              tail_ptr
);

    rob_ptr_t used_cnt;
    rob_ptr_t free_cnt;
    logic [1:0] req_cnt;

    always_comb begin
        req_cnt      = lane_count(alloc_valid);
        used_cnt     = tail_ptr - head_ptr;
        free_cnt     = rob_ptr_t'(ROB_DEPTH) - used_cnt;
        alloc_ready  = free_cnt >= rob_ptr_t'(req_cnt);
        alloc_fire   = (alloc_ready && !flush) ? alloc_valid : '0;
        alloc_idx[0] = tail_ptr[IDX_W-1:0];
        alloc_idx[1] = tail_ptr[IDX_W-1:0] + rob_idx_t'(alloc_valid[0]);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_ptr <= '0;
            tail_ptr <= '0;
        end else begin
            tail_ptr <= ptr_add(tail_ptr, lane_count(alloc_fire));
            head_ptr <= ptr_add(head_ptr, retire_cnt);
        end
    end

endmodule

// File: rtl/rob_storage.sv
module rob_storage
    import rob_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [LANES-1:0]             alloc_fire,
    input  rob_idx_t                     alloc_idx [LANES],
    input  logic [LANES-1:0][REG_W-1:0]  alloc_dst,
    input  logic [LANES-1:0]             alloc_store,
    input  logic [LANES-1:0][SB_W-1:0]   alloc_sbidx,
    input  logic [LANES-1:0]             wb_valid,
    input  logic [LANES-1:0][IDX_W-1:0]  wb_tag,
    input  logic [LANES-1:0][DATA_W-1:0] wb_value,
    input  logic [LANES-1:0]             retire,
    input  rob_idx_t                     retire_idx [LANES],
    output rob_entry_t                   ent [ROB_DEPTH]
);

    for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_entry
        localparam rob_idx_t MY_IDX = rob_idx_t'(i);
        logic [LANES-1:0] hit_alloc;
        logic [LANES-1:0] hit_wb;
        logic [LANES-1:0] hit_retire;

        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign hit_alloc[k]  = alloc_fire[k] && (alloc_idx[k] == MY_IDX);
            assign hit_wb[k]     = wb_valid[k]   && (wb_tag[k] == MY_IDX);
            assign hit_retire[k] = retire[k]     && (retire_idx[k] == MY_IDX);
        end

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent[i] <= '0;
            end else if (hit_alloc[0]) begin
                ent[i] <= '{valid: 1'b1, done: 1'b0, is_store: alloc_store[0],
                            dst: alloc_dst[0], sbidx: alloc_sbidx[0], value: '0};
            end else if (hit_alloc[1]) begin
                ent[i] <= '{valid: 1'b1, done: 1'b0, is_store: alloc_store[1],
                            dst: alloc_dst[1], sbidx: alloc_sbidx[1], value: '0};
            end else if (ent[i].valid) begin
                if (|hit_retire) begin
                    ent[i].valid <= 1'b0;
                    ent[i].done  <= 1'b0;
                end else if (hit_wb[1]) begin
                    ent[i].done  <= 1'b1;
                    ent[i].value <= wb_value[1];
                end else if (hit_wb[0]) begin
                    ent[i].done  <= 1'b1;
                    ent[i].value <= wb_value[0];
                end
            end
        end
    end

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
(
    input  logic                         flush,
    input  rob_ptr_t                     head_ptr,
    input  rob_entry_t                   ent [ROB_DEPTH],
    output logic [LANES-1:0]             retire,
    output rob_idx_t                     retire_idx [LANES],
    output logic [1:0]                   retire_cnt,
    output logic [LANES-1:0]             rf_we,
    output logic [LANES-1:0][REG_W-1:0]  rf_addr,
    output logic [LANES-1:0][DATA_W-1:0] rf_data,
    output logic [LANES-1:0]             st_commit,
    output logic [LANES-1:0][SB_W-1:0]   st_idx
);

    rob_entry_t head_ent [LANES];
    logic [LANES-1:0] ready_ent;

    always_comb begin
        retire_idx[0] = head_ptr[IDX_W-1:0];
        retire_idx[1] = head_ptr[IDX_W-1:0] + rob_idx_t'(1);
        for (int k = 0; k < LANES; k++) begin
            head_ent[k]  = ent[retire_idx[k]];
            ready_ent[k] = head_ent[k].valid && head_ent[k].done;
        end
        retire[0]  = !flush && ready_ent[0];
        retire[1]  = retire[0] && ready_ent[1];
        retire_cnt = lane_count(retire);
        for (int k = 0; k < LANES; k++) begin
            rf_we[k]     = retire[k] && !head_ent[k].is_store;
            st_commit[k] = retire[k] &&  head_ent[k].is_store;
            rf_addr[k]   = head_ent[k].dst;
            rf_data[k]   = head_ent[k].value;
            st_idx[k]    = head_ent[k].sbidx;
        end
    end

endmodule

// File: rtl/rob_dual_commit.sv
module rob_dual_commit
    import rob_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [LANES-1:0]             alloc_valid,
    input  logic [LANES-1:0][REG_W-1:0]  alloc_dst,
    input  logic [LANES-1:0]             alloc_store,
    input  logic [LANES-1:0][SB_W-1:0]   alloc_sbidx,
    output logic                         alloc_ready,
    output logic [LANES-1:0][IDX_W-1:0]  alloc_tag,
    input  logic [LANES-1:0]             wb_valid,
    input  logic [LANES-1:0][IDX_W-1:0]  wb_tag,
    input  logic [LANES-1:0][DATA_W-1:0] wb_value,
    output logic [LANES-1:0]             rf_we,
    output logic [LANES-1:0][REG_W-1:0]  rf_addr,
    output logic [LANES-1:0][DATA_W-1:0] rf_data,
    output logic [LANES-1:0]             st_commit,
    output logic [LANES-1:0][SB_W-1:0]   st_idx
);

    logic [LANES-1:0] alloc_fire;
    rob_idx_t         alloc_idx [LANES];
    rob_ptr_t         head_ptr;
    rob_ptr_t         tail_ptr;
    logic [LANES-1:0] retire;
    rob_idx_t         retire_idx [LANES];
    logic [1:0]       retire_cnt;
    rob_entry_t       ent [ROB_DEPTH];

    assign alloc_tag[0] = alloc_idx[0];
    assign alloc_tag[1] = alloc_idx[1];

    rob_ptr_ctrl u_ptr (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .alloc_valid (alloc_valid),
        .retire_cnt  (retire_cnt),
        .alloc_ready (alloc_ready),
        .alloc_fire  (alloc_fire),
        .alloc_idx   (alloc_idx),
        .head_ptr    (head_ptr),
        .tail_ptr    (tail_ptr)
    );

    rob_storage u_store (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .alloc_fire  (alloc_fire),
        .alloc_idx   (alloc_idx),
        .alloc_dst   (alloc_dst),
        .alloc_store (alloc_store),
        .alloc_sbidx (alloc_sbidx),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .wb_value    (wb_value),
        .retire      (retire),
        .retire_idx  (retire_idx),
        .ent         (ent)
    );

    rob_retire u_retire (
        .flush      (flush),
        .head_ptr   (head_ptr),
        .ent        (ent),
        .retire     (retire),
        .retire_idx (retire_idx),
        .retire_cnt (retire_cnt),
        .rf_we      (rf_we),
        .rf_addr    (rf_addr),
        .rf_data    (rf_data),
        .st_commit  (st_commit),
        .st_idx     (st_idx)
    );

endmodule

// File: rtl/rob_dual_commit_chk.sv
module rob_dual_commit_chk
    import rob_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             alloc_ready,
    input logic [LANES-1:0] rf_we,
    input logic [LANES-1:0] st_commit,
    input rob_ptr_t         head_ptr,
    input rob_ptr_t         tail_ptr
);

    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rf_we[1] || st_commit[1]) |-> (rf_we[0] || st_commit[0]));                 // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!alloc_ready && !flush) |=> (tail_ptr == $past(tail_ptr)));                 // R7

    AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        rob_ptr_t'(tail_ptr - head_ptr) <= rob_ptr_t'(ROB_DEPTH));                    // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (head_ptr == '0 && tail_ptr == '0));                               // R9

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (rob_ptr_t'(head_ptr - $past(head_ptr)) <= rob_ptr_t'(2)));       // R4

endmodule

bind rob_dual_commit rob_dual_commit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .alloc_ready (alloc_ready),
    .rf_we       (rf_we),
    .st_commit   (st_commit),
    .head_ptr    (head_ptr),
    .tail_ptr    (tail_ptr)
);

// File: tb/rob_dual_commit_test.sv
module rob_dual_commit_test;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic [LANES-1:0]             alloc_valid = '0;
    logic [LANES-1:0][REG_W-1:0]  alloc_dst   = '0;
    logic [LANES-1:0]             alloc_store = '0;
    logic [LANES-1:0][SB_W-1:0]   alloc_sbidx = '0;
    logic                         alloc_ready;
    logic [LANES-1:0][IDX_W-1:0]  alloc_tag;
    logic [LANES-1:0]             wb_valid = '0;
    logic [LANES-1:0][IDX_W-1:0]  wb_tag   = '0;
    logic [LANES-1:0][DATA_W-1:0] wb_value = '0;
    logic [LANES-1:0]             rf_we;
    logic [LANES-1:0][REG_W-1:0]  rf_addr;
    logic [LANES-1:0][DATA_W-1:0] rf_data;
    logic [LANES-1:0]             st_commit;
    logic [LANES-1:0][SB_W-1:0]   st_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_dual_commit uut (.*);

    typedef struct { bit st; int id; int val; } exp_t;
    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every active retire lane must match the oldest expected item
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < LANES; k++) begin
                if (rf_we[k] || st_commit[k]) begin
                    if (q.size() == 0) begin
                        chk("R3 unexpected retire", 0, k, -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk("R6 lane kind", st_commit[k] == e.st, int'(st_commit[k]), int'(e.st));
                        if (e.st)
                            chk("R6 store slot", int'(st_idx[k]) == e.id, int'(st_idx[k]), e.id);
                        else begin
                            chk("R3 dest reg", int'(rf_addr[k]) == e.id, int'(rf_addr[k]), e.id);
                            chk("R3 value", int'(rf_data[k]) == e.val, int'(rf_data[k]), e.val);
                        end
                    end
                end
            end
        end
    end

    // Driver: called just after a rising edge; requests one cycle of allocation
    task automatic alloc(input bit v0, input bit s0, input int id0, input int val0,
                         input bit v1, input bit s1, input int id1, input int val1,
                         output bit rdy, output int t0, output int t1);
        alloc_valid    = {v1, v0};
        alloc_store    = {s1, s0};
        alloc_dst[0]   = id0[REG_W-1:0];
        alloc_dst[1]   = id1[REG_W-1:0];
        alloc_sbidx[0] = id0[SB_W-1:0];
        alloc_sbidx[1] = id1[SB_W-1:0];
        #1;
        rdy = alloc_ready;
        t0  = int'(alloc_tag[0]);
        t1  = int'(alloc_tag[1]);
        if (rdy) begin
            if (v0) q.push_back('{st: s0, id: id0, val: val0});
            if (v1) q.push_back('{st: s1, id: id1, val: val1});
        end
        @(posedge clk); #1;
        alloc_valid = '0;
    endtask

    task automatic wb(input bit v0, input int t0, input int val0,
                      input bit v1, input int t1, input int val1);
        wb_valid    = {v1, v0};
        wb_tag[0]   = t0[IDX_W-1:0];
        wb_tag[1]   = t1[IDX_W-1:0];
        wb_value[0] = val0;
        wb_value[1] = val1;
        @(posedge clk); #1;
        wb_valid = '0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    initial begin
        bit rdy;
        int t0, t1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1 no retire after reset", (rf_we == 0) && (st_commit == 0), int'(rf_we), 0);
        idle();

        // R10: writeback to unoccupied entry 0 is dropped
        wb(1, 0, 999, 0, 0, 0);

        // R1 / R2: first allocations get tags 0..3
        alloc(1, 0, 1, 100, 1, 0, 2, 101, rdy, t0, t1);
        chk("R1 ready for two", rdy, int'(rdy), 1);
        chk("R1 tag0", t0 == 0, t0, 0);
        chk("R2 tag1 follows", t1 == 1, t1, 1);
        alloc(1, 0, 3, 102, 1, 0, 4, 103, rdy, t0, t1);
        chk("R2 tail advanced", t0 == 2 && t1 == 3, t0, 2);

        // R3: reverse-order writebacks, nothing retires while head is incomplete
        wb(1, 3, 103, 1, 2, 102);
        wb(1, 1, 101, 0, 0, 0);
        @(negedge clk);
        chk("R10 stale wb did not complete entry", rf_we == 0, int'(rf_we), 0);
        idle();

        // R4: head writeback releases two per cycle
        wb(1, 0, 100, 0, 0, 0);
        @(negedge clk);
        chk("R4 dual retire", rf_we == 2'b11, int'(rf_we), 3);
        chk("R4 older on lane0", rf_addr[0] == 5'd1 && rf_addr[1] == 5'd2, int'(rf_addr[0]), 1);
        idle();
        @(negedge clk);
        chk("R3 next pair in order", rf_we == 2'b11 && rf_addr[0] == 5'd3, int'(rf_addr[0]), 3);
        idle();

        // R5: second entry complete, first not
        alloc(1, 0, 5, 200, 1, 0, 6, 201, rdy, t0, t1);
        chk("R2 tags 4,5", t0 == 4 && t1 == 5, t0, 4);
        wb(0, 0, 0, 1, 5, 201);
        @(negedge clk);
        chk("R5 lane1 blocked", rf_we == 0, int'(rf_we), 0);
        idle();
        wb(1, 4, 200, 0, 0, 0);
        @(negedge clk);
        chk("R5 pair released", rf_we == 2'b11, int'(rf_we), 3);
        idle();

        // R6: store retirement
        alloc(1, 1, 6, 300, 1, 0, 7, 301, rdy, t0, t1);
        wb(1, t0, 300, 1, t1, 301);
        @(negedge clk);
        chk("R6 store strobe", st_commit == 2'b01 && st_idx[0] == 3'd6, int'(st_commit), 1);
        chk("R6 no rf write on store lane", rf_we == 2'b10, int'(rf_we), 2);
        idle();

        // R7 / R8: fill after the wrap
        alloc(1, 0, 8, 400, 1, 0, 9, 401, rdy, t0, t1);
        chk("R8 wrapped tag", t0 == 0, t0, 0);
        alloc(1, 0, 10, 402, 1, 0, 11, 403, rdy, t0, t1);
        alloc(1, 0, 12, 404, 1, 0, 13, 405, rdy, t0, t1);
        alloc(1, 0, 14, 406, 0, 0, 0, 0, rdy, t0, t1);
        alloc(1, 0, 15, 407, 1, 0, 16, 408, rdy, t0, t1);
        chk("R7 two refused with one free", !rdy, int'(rdy), 0);
        alloc(1, 0, 15, 407, 0, 0, 0, 0, rdy, t0, t1);
        chk("R7 single accepted", rdy, int'(rdy), 1);
        chk("R7 tail held", t0 == 7, t0, 7);
        alloc(1, 0, 17, 409, 0, 0, 0, 0, rdy, t0, t1);
        chk("R8 full refuses one", !rdy, int'(rdy), 0);
        for (int p = 0; p < 4; p++)
            wb(1, 2*p, 400 + 2*p, 1, 2*p + 1, 401 + 2*p);
        repeat (3) idle();

        // R9: flush
        alloc(1, 0, 18, 500, 1, 0, 19, 501, rdy, t0, t1);
        chk("R8 drained then tag0", t0 == 0, t0, 0);
        alloc(1, 0, 20, 502, 0, 0, 0, 0, rdy, t0, t1);
        wb(0, 0, 0, 1, 1, 501);
        flush = 1'b1;
        q.delete();
        @(negedge clk);
        chk("R9 no retire during flush", (rf_we == 0) && (st_commit == 0), int'(rf_we), 0);
        @(posedge clk); #1;
        flush = 1'b0;
        wb(1, 0, 500, 0, 0, 0);
        @(negedge clk);
        chk("R9 flushed tag ignored", rf_we == 0, int'(rf_we), 0);
        idle();
        alloc(1, 0, 21, 600, 0, 0, 0, 0, rdy, t0, t1);
        chk("R9 pointers reset", t0 == 0, t0, 0);
        wb(1, 0, 600, 0, 0, 0);
        repeat (3) idle();
        chk("R3 all expected retired", q.size() == 0, q.size(), 0);
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                #(CLK_PERIOD * 100000);
                chk("watchdog expired", 0, 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule